// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the device side of a small serial memory that holds 64 words of 16 bits. A host drives a select line, a serial clock and a data-in line. The engine samples all three with a fast system clock. After the select line goes high, it waits for a start bit, shifts in a two-bit opcode and a six-bit address, and then decodes one of seven instructions. Reads return a dummy zero followed by the addressed word on data-out. Programming instructions (write one word, erase one word, write all words, erase all words) are guarded by a programming-enable latch. Each one starts a self-timed cycle whose length is a parameter counted in system clocks.

While a programming cycle runs, the host polls it by dropping the select line and raising it again. Data-out then shows 0 while the cycle is busy and 1 once it has finished. If the select line rises only after the cycle has ended, no status is driven. Data-out has an enable flag that is low whenever the select line is low. The storage array is kept in registers and comes out of reset fully erased (all ones).

The state machine has these states:
- S_IDLE: select low.
- S_WAIT_SB: hunting for the start bit.
- S_OPC: opcode shift.
- S_ADDR: address shift and decode.
- S_DATA: data shift for write instructions.
- S_READ: dummy bit and word shift-out.
- S_STATUS: ready/busy display.
- S_DONE: instruction finished, waiting for select low.

Transitions:
- Select low sends every state to S_IDLE.
- S_IDLE goes to S_STATUS if a programming cycle is running, otherwise to S_WAIT_SB.
- S_WAIT_SB goes to S_OPC on a serial-clock rise with data-in high.
- S_OPC goes to S_ADDR after two bits.
- S_ADDR, after six bits, goes to S_READ for a read, to S_DATA for a word write or a write-all, and to S_DONE for everything else.
- S_DATA goes to S_DONE after sixteen bits.
- S_READ goes to S_DONE on the rise after the last data bit.

Top module: `ser_eeprom_engine`

## Requirements
- R1: After the synchronised select goes high, leading zeros on data-in are ignored. The first 1 sampled on a serial-clock rise is the start bit. It is followed by a 2-bit opcode and a 6-bit address, each sent MSB first.
- R2: Opcode 10 is a read. On the clock rise that samples the last address bit, data-out is enabled and shows a dummy 0. Each following rise presents the next bit of the addressed word, MSB first. Reads work whether or not programming is enabled.
- R3: The programming-enable latch is clear after reset. Opcode 00 with address bits [5:4] = 11 sets it, and 00 with [5:4] = 00 clears it. While it is clear, word write, word erase, write-all and erase-all leave the array unchanged and start no cycle.
- R4: Opcode 01 is a word write. Sixteen data bits follow the address, MSB first. The word is replaced without a prior erase.
- R5: Opcode 11 is a word erase. The addressed word becomes all ones, and the cycle starts right after the last address bit.
- R6: Opcode 00 with [5:4] = 01 is write-all, which takes 16 data bits and writes them to every word. Opcode 00 with [5:4] = 10 is erase-all, which sets every word to all ones. The low four address bits are ignored.
- R7: If select goes low and then high while a programming cycle lasting PROG_CYCLES system clocks is running, data-out is enabled. It shows 0 while the cycle is busy and 1 once the cycle has ended.
- R8: If select rises after the cycle has ended, or when no cycle was started, data-out stays disabled until a read drives it.
- R9: Data-out is disabled whenever select has been low for longer than the synchroniser latency.
- R10: Select going low before an instruction is complete aborts it. The array is unchanged and no cycle starts.
- R11: An instruction shifted in while a programming cycle is running is ignored.
- R12: After reset, data-out is disabled and low, and every word reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_in | input | 1 | Asynchronous select from the host, high while selected |
| sclk_in | input | 1 | Asynchronous serial clock from the host |
| din_in | input | 1 | Asynchronous serial data from the host |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | High when dout is driven, low models high impedance |

## Verification
The end of a programming cycle and a re-raise of select can land in the same system clock. In that case the engine must decide between S_STATUS and S_WAIT_SB while busy is falling. The bench provokes this by stepping the delay between the end of a write instruction and the next select rise, three clocks at a time, across the expected end of the cycle. Whatever branch the engine takes, once the cycle has surely finished the bench requires data-out to be either disabled or showing ready, never stuck at busy. It also requires the written word to read back correctly.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_SB,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_READ,
        S_STATUS,
        S_DONE
    } eep_state_t;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_EWEN,
        CMD_EWDS,
        CMD_ERAL,
        CMD_WRAL
    } eep_cmd_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_DIS  = 2'b00;
    localparam logic [1:0] SUB_WALL = 2'b01;
    localparam logic [1:0] SUB_EALL = 2'b10;
    localparam logic [1:0] SUB_EN   = 2'b11;

    // opcode plus the two top address bits select the command
    function automatic eep_cmd_t decode_cmd(input logic [1:0] opc, input logic [1:0] sub);
        eep_cmd_t c;
        unique case (opc)
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            OPC_ERASE: c = CMD_ERASE;
            default: begin
                unique case (sub)
                    SUB_EN:   c = CMD_EWEN;
                    SUB_DIS:  c = CMD_EWDS;
                    SUB_EALL: c = CMD_ERAL;
                    default:  c = CMD_WRAL;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl
);
    logic [N-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= CW'(CYCLES);
            busy <= 1'b1;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) busy <= 1'b0;
        end
    end

    // commit pulse coincides with the last busy clock
    assign done = busy && (cnt == CW'(1));
endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
    parameter int WORDS = 64,
    parameter int WIDTH = 16,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             commit_all,
    input  logic [AW-1:0]    commit_addr,
    input  logic [WIDTH-1:0] commit_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [WORDS];
    logic [WORDS-1:0] wsel;

    genvar w;
    generate
        for (w = 0; w < WORDS; w++) begin : g_sel
            assign wsel[w] = commit && (commit_all || (commit_addr == AW'(w)));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++)
                if (wsel[i]) mem[i] <= commit_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ser_eeprom_engine.sv
module ser_eeprom_engine
    import eep_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int WIDTH       = 16,
    parameter int PROG_CYCLES = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_in,
    input  logic sclk_in,
    input  logic din_in,
    output logic dout,
    output logic dout_oe
);
    localparam int AW    = $clog2(WORDS);
    localparam int BW    = $clog2(WIDTH + 1);
    localparam int OPC_W = 2;

    // ---------------- input conditioning ----------------
    logic [2:0] sync_lvl;
    logic       cs_lvl, sk_lvl, di_lvl, sk_prev, sk_rise;

    eep_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_in, sclk_in, din_in}),
        .lvl      (sync_lvl)
    );

    assign cs_lvl  = sync_lvl[2];
    assign sk_lvl  = sync_lvl[1];
    assign di_lvl  = sync_lvl[0];
    assign sk_rise = sk_lvl && !sk_prev;

    // ---------------- state and datapath registers ----------------
    eep_state_t       state, nxt;
    logic [BW-1:0]    bit_cnt;
    logic [1:0]       opc_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH:0]   out_sr;
    eep_cmd_t         cmd_q;
    logic             en_q;
    logic             pend_all;
    logic [AW-1:0]    pend_addr;
    logic [WIDTH-1:0] pend_data;

    // ---------------- shift-in views ----------------
    logic [AW-1:0]    addr_nx;
    logic [WIDTH-1:0] data_nx;
    eep_cmd_t         cmd_nx;
    logic             last_opc, last_addr, last_data, read_end;

    assign addr_nx   = {addr_q[AW-2:0], di_lvl};
    assign data_nx   = {data_q[WIDTH-2:0], di_lvl};
    assign cmd_nx    = decode_cmd(opc_q, addr_nx[AW-1:AW-2]);
    assign last_opc  = (bit_cnt == BW'(OPC_W - 1));
    assign last_addr = (bit_cnt == BW'(AW - 1));
    assign last_data = (bit_cnt == BW'(WIDTH - 1));
    assign read_end  = (bit_cnt == BW'(WIDTH));

    // ---------------- programming launch ----------------
    logic             erase_go, write_go, prog_start;
    logic             start_all;
    logic [AW-1:0]    start_addr;
    logic [WIDTH-1:0] start_data;
    logic             busy, prog_done;
    logic [WIDTH-1:0] rd_data;

    assign erase_go   = (state == S_ADDR) && last_addr &&
                        ((cmd_nx == CMD_ERASE) || (cmd_nx == CMD_ERAL));
    assign write_go   = (state == S_DATA) && last_data;
    assign prog_start = cs_lvl && sk_rise && en_q && (erase_go || write_go);
    assign start_all  = erase_go ? (cmd_nx == CMD_ERAL) : (cmd_q == CMD_WRAL);
    assign start_addr = erase_go ? addr_nx : addr_q;
    assign start_data = erase_go ? {WIDTH{1'b1}} : data_nx;

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy),
        .done  (prog_done)
    );

    eep_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (prog_done),
        .commit_all  (pend_all),
        .commit_addr (pend_addr),
        .commit_data (pend_data),
        .rd_addr     (addr_nx),
        .rd_data     (rd_data)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        nxt = state;
        if (!cs_lvl) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    nxt = busy ? S_STATUS : S_WAIT_SB;
                S_WAIT_SB: if (sk_rise && di_lvl) nxt = S_OPC;
                S_OPC:     if (sk_rise && last_opc) nxt = S_ADDR;
                S_ADDR: begin
                    if (sk_rise && last_addr) begin
                        unique case (cmd_nx)
                            CMD_READ:            nxt = S_READ;
                            CMD_WRITE, CMD_WRAL: nxt = S_DATA;
                            default:             nxt = S_DONE;
                        endcase
                    end
                end
                S_DATA:    if (sk_rise && last_data) nxt = S_DONE;
                S_READ:    if (sk_rise && read_end) nxt = S_DONE;
                S_STATUS:  nxt = S_STATUS;
                S_DONE:    nxt = S_DONE;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_prev   <= 1'b0;
            bit_cnt   <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            out_sr    <= '0;
            cmd_q     <= CMD_READ;
            en_q      <= 1'b0;
            pend_all  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            sk_prev <= sk_lvl;
            if (prog_start) begin
                pend_all  <= start_all;
                pend_addr <= start_addr;
                pend_data <= start_data;
            end
            if (cs_lvl && sk_rise) begin
                unique case (state)
                    S_WAIT_SB: bit_cnt <= '0;
                    S_OPC: begin
                        opc_q   <= {opc_q[0], di_lvl};
                        bit_cnt <= last_opc ? '0 : bit_cnt + 1'b1;
                    end
                    S_ADDR: begin
                        addr_q <= addr_nx;
                        if (last_addr) begin
                            bit_cnt <= '0;
                            cmd_q   <= cmd_nx;
                            out_sr  <= {1'b0, rd_data};
                            if (cmd_nx == CMD_EWEN) en_q <= 1'b1;
                            if (cmd_nx == CMD_EWDS) en_q <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        data_q  <= data_nx;
                        bit_cnt <= last_data ? '0 : bit_cnt + 1'b1;
                    end
                    S_READ: begin
                        out_sr  <= {out_sr[WIDTH-1:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    logic in_read, in_status;

    always_comb begin
        in_read   = (state == S_READ);
        in_status = (state == S_STATUS);
        dout_oe   = in_read || in_status;
        dout      = 1'b0;
        if (in_status)    dout = !busy;
        else if (in_read) dout = out_sr[WIDTH];
    end

endmodule

// File: rtl/eep_engine_checker.sv
module eep_engine_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_in,
    input logic dout,
    input logic dout_oe,
    input logic cs_lvl,
    input logic prog_start,
    input logic prog_en,
    input logic busy,
    input logic in_read,
    input logic in_status
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_run <= '0;
        else if (cs_in)        low_run <= '0;
        else if (low_run != '1) low_run <= low_run + 1'b1;
    end

    assert_hiz_when_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_in && (low_run >= 8'(SYNC_STAGES + 1))) |-> !dout_oe);

    assert_prog_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> prog_en);

    assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);

    assert_busy_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    assert_status_tracks_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_status |-> (dout_oe && (dout == !busy)));

    assert_read_dummy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_read) |-> (dout_oe && !dout));

    assert_abort_starts_nothing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |-> !prog_start);
endmodule

bind ser_eeprom_engine eep_engine_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_in      (cs_in),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .cs_lvl     (cs_lvl),
    .prog_start (prog_start),
    .prog_en    (en_q),
    .busy       (busy),
    .in_read    (in_read),
    .in_status  (in_status)
);

// File: tb/ser_eeprom_engine_test.sv
`timescale 1ns/1ps
module ser_eeprom_engine_test;
    localparam int PC   = 300;
    localparam int HALF = 6;
    localparam int C_READ = 0, C_WRITE = 1, C_ERASE = 2, C_EWEN = 3,
                   C_EWDS = 4, C_ERAL = 5, C_WRAL = 6;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, oe;
    logic s_dout, s_oe;
    int   n_chk = 0, n_fail = 0;
    logic [15:0] mdl [64];
    bit   men = 1'b0;

    always #4 clk = ~clk;

    ser_eeprom_engine #(.PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_in(cs), .sclk_in(sk), .din_in(di),
        .dout(dout), .dout_oe(oe));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        @(negedge clk) di = b;
        clk_wait(HALF);
        sk = 1'b1;
        clk_wait(HALF);
        s_dout = dout;
        s_oe   = oe;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic cs_up();
        clk_wait(2);
        cs = 1'b1;
        clk_wait(6);
        s_dout = dout;
        s_oe   = oe;
    endtask

    task automatic cs_down();
        @(negedge clk);
        sk = 1'b0;
        cs = 1'b0;
        clk_wait(6);
        check(oe == 1'b0, "R9 oe low after deselect", oe, 0);
    endtask

    function automatic logic [1:0] enc_op(input int c);
        case (c)
            C_READ:  return 2'b10;
            C_WRITE: return 2'b01;
            C_ERASE: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [5:0] enc_addr(input int c, input logic [5:0] a);
        case (c)
            C_EWEN:  return {2'b11, a[3:0]};
            C_EWDS:  return {2'b00, a[3:0]};
            C_ERAL:  return {2'b10, a[3:0]};
            C_WRAL:  return {2'b01, a[3:0]};
            default: return a;
        endcase
    endfunction

    function automatic bit has_data(input int c);
        return (c == C_WRITE) || (c == C_WRAL);
    endfunction

    function automatic bit starts_cycle(input int c, input bit en);
        return en && (c == C_WRITE || c == C_ERASE || c == C_ERAL || c == C_WRAL);
    endfunction

    task automatic model_apply(input int c, input logic [5:0] a, input logic [15:0] d);
        case (c)
            C_EWEN: men = 1'b1;
            C_EWDS: men = 1'b0;
            C_WRITE: if (men) mdl[a] = d;
            C_ERASE: if (men) mdl[a] = 16'hFFFF;
            C_WRAL: if (men) for (int i = 0; i < 64; i++) mdl[i] = d;
            C_ERAL: if (men) for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
            default: ;
        endcase
    endtask

    task automatic read_word(input logic [5:0] a, input int zeros, output logic [15:0] w);
        cs_up();
        for (int i = 0; i < zeros; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        send({30'd0, 2'b10}, 2);
        send({26'd0, a}, 6);
        check(s_oe && !s_dout, "R2 dummy zero with oe", {s_oe, s_dout}, 2'b10);
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0);
            w[i] = s_dout;
        end
        cs_down();
    endtask

    task automatic send_instr(input int c, input logic [5:0] a, input logic [15:0] d);
        sk_bit(1'b1);
        send({30'd0, enc_op(c)}, 2);
        send({26'd0, enc_addr(c, a)}, 6);
        if (has_data(c)) send({16'd0, d}, 16);
    endtask

    // wait for ready by repeated select toggles; returns true if seen
    task automatic poll_ready(output bit seen);
        seen = 1'b0;
        for (int p = 0; p < 200 && !seen; p++) begin
            cs_up();
            if (s_oe && s_dout) seen = 1'b1;
            cs_down();
        end
    endtask

    task automatic run_cmd(input int c, input logic [5:0] a, input logic [15:0] d);
        bit go, seen;
        go = starts_cycle(c, men);
        cs_up();
        send_instr(c, a, d);
        cs_down();
        cs_up();
        if (go) begin
            check(s_oe && !s_dout, "R7 busy status", {s_oe, s_dout}, 2'b10);
            cs_down();
            poll_ready(seen);
            check(seen, "R7 ready seen", seen, 1);
            cs_up();
            check(!s_oe, "R8 no status after cycle end", s_oe, 0);
        end else begin
            check(!s_oe, "R8 R3 no cycle started", s_oe, 0);
        end
        cs_down();
        model_apply(c, a, d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int r, c;
        logic [5:0] a;
        logic [15:0] d;
        bit seen, any_status;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
        clk_wait(10);
        rst_n = 1'b1;
        clk_wait(4);

        // R12 reset state
        check(!oe && !dout, "R12 outputs after reset", {oe, dout}, 0);
        read_word(6'd0, 0, w);
        check(w == 16'hFFFF, "R12 word 0 erased", w, 16'hFFFF);
        read_word(6'd63, 0, w);
        check(w == 16'hFFFF, "R12 word 63 erased", w, 16'hFFFF);

        // R3 write while disabled
        run_cmd(C_WRITE, 6'd5, 16'h1111);
        read_word(6'd5, 0, w);
        check(w == mdl[5], "R3 disabled write ignored", w, mdl[5]);

        // R4 write after enable
        run_cmd(C_EWEN, 6'd0, 16'h0);
        run_cmd(C_WRITE, 6'd5, 16'hA5C3);
        read_word(6'd5, 0, w);
        check(w == 16'hA5C3, "R4 word written", w, 16'hA5C3);
        run_cmd(C_WRITE, 6'd5, 16'h0F0F);
        read_word(6'd5, 0, w);
        check(w == 16'h0F0F, "R4 overwrite without erase", w, 16'h0F0F);

        // R1 leading zeros before start bit
        read_word(6'd5, 3, w);
        check(w == 16'h0F0F, "R1 leading zeros ignored", w, 16'h0F0F);

        // R5 erase
        run_cmd(C_ERASE, 6'd5, 16'h0);
        read_word(6'd5, 0, w);
        check(w == 16'hFFFF, "R5 word erased", w, 16'hFFFF);

        // R10 abort mid-data
        run_cmd(C_WRITE, 6'd9, 16'h3C3C);
        cs_up();
        sk_bit(1'b1);
        send({30'd0, 2'b01}, 2);
        send(32'd9, 6);
        send(32'h00AB, 8);
        cs_down();
        cs_up();
        check(!s_oe, "R10 abort starts no cycle", s_oe, 0);
        cs_down();
        read_word(6'd9, 0, w);
        check(w == 16'h3C3C, "R10 aborted write leaves word", w, 16'h3C3C);

        // R11 instruction during busy ignored
        cs_up();
        send_instr(C_WRITE, 6'd20, 16'h2020);
        cs_down();
        model_apply(C_WRITE, 6'd20, 16'h2020);
        cs_up();
        send_instr(C_WRITE, 6'd21, 16'h2121);
        check(s_oe, "R11 status held while busy", s_oe, 1);
        cs_down();
        poll_ready(seen);
        read_word(6'd21, 0, w);
        check(w == mdl[21], "R11 busy instruction ignored", w, mdl[21]);
        read_word(6'd20, 0, w);
        check(w == 16'h2020, "R4 write before busy", w, 16'h2020);

        // R6 write-all and erase-all
        run_cmd(C_WRAL, 6'd7, 16'h1234);
        read_word(6'd0, 0, w);
        check(w == 16'h1234, "R6 write-all word 0", w, 16'h1234);
        read_word(6'd63, 0, w);
        check(w == 16'h1234, "R6 write-all word 63", w, 16'h1234);
        run_cmd(C_ERAL, 6'd3, 16'h0);
        read_word(6'd33, 0, w);
        check(w == 16'hFFFF, "R6 erase-all", w, 16'hFFFF);

        // R3 disable then erase ignored, read still works
        run_cmd(C_WRITE, 6'd40, 16'h4040);
        run_cmd(C_EWDS, 6'd0, 16'h0);
        run_cmd(C_ERASE, 6'd40, 16'h0);
        read_word(6'd40, 0, w);
        check(w == 16'h4040, "R3 erase after disable ignored", w, 16'h4040);
        run_cmd(C_EWEN, 6'd0, 16'h0);

        // boundary sweep: select re-raise around the end of the cycle (R7, R8)
        for (int s = 0; s < 20; s++) begin
            d = 16'h5A00 + 16'(s);
            cs_up();
            send_instr(C_WRITE, 6'd50, d);
            cs_down();
            clk_wait(PC - 40 + 3 * s);
            cs_up();
            clk_wait(40);
            any_status = oe;
            check(!oe || dout, "R7 R8 boundary not stuck busy", {oe, dout}, 2'b11);
            cs_down();
            if (any_status) begin
                poll_ready(seen);
            end
            model_apply(C_WRITE, 6'd50, d);
            read_word(6'd50, 0, w);
            check(w == d, "R4 boundary write value", w, d);
        end

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            r = $urandom_range(0, 19);
            if (r < 6)       c = C_WRITE;
            else if (r < 10) c = C_READ;
            else if (r < 13) c = C_ERASE;
            else if (r < 15) c = C_EWEN;
            else if (r < 17) c = C_EWDS;
            else if (r == 17) c = C_WRAL;
            else if (r == 18) c = C_ERAL;
            else             c = C_EWEN;
            a = 6'($urandom_range(0, 63));
            d = 16'($urandom);
            if (c != C_READ) run_cmd(c, a, d);
            read_word(a, 0, w);
            check(w == mdl[a], "R2 random read-back", w, mdl[a]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule